// File: doc/BRIEF.md
# Context-Tagged Translation Cache

This block keeps a small, fully associative set of recently used page translations in front of a slower page-map lookup. Every entry holds a valid flag, an address-space context tag, a virtual page number, a physical page number and a dirty flag. A lookup presents a context and a virtual address. All entries are compared against both in the same cycle. On a hit, the physical address comes out on the next clock edge.

On a miss, the block latches the request and raises a refill request on its page-map port. It waits for the answer, writes the returned mapping into a victim slot and then completes the lookup with the new physical address. If the page map reports the page as not resident, nothing is written and a fault carrying the virtual page number is raised instead. Only one refill can be outstanding at a time: the request-ready output stays low until the refill completes.

Because each entry carries a context tag, translations from several address spaces can be held together, and a context switch does not need a flush. Software can still clear every entry, or only the entries of one context.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1, and `resp_valid`, `resp_fault` and `walk_req` are 0. The first lookup after reset therefore always raises a refill.
- R2: A lookup that matches a valid entry on both context and virtual page number produces a result one clock after it is accepted, with no refill. `resp_valid` is 1, `resp_paddr` is {entry physical page, request offset} with the offset in the low `OFF_W` bits, and `resp_dirty` is the dirty flag of the entry.
- R3: An entry matches only when its context equals `req_ctx`. A lookup with the same virtual page number under another context misses. Afterwards both mappings coexist, and each of them hits with its own physical page.
- R4: On a miss, `walk_req` rises one clock after acceptance, with `walk_ctx` and `walk_vpn` set to the request. `walk_req` is held until a clock in which `walk_ack` is 1. `req_ready` stays 0 from acceptance until the result is delivered.
- R5: A clock with `walk_req` and `walk_ack` both 1 and `walk_resident` = 1 produces `resp_valid` on the next clock, with `resp_paddr` = {`walk_ppn`, offset} and `resp_dirty` = `walk_dirty`. The mapping is installed, so a repeat lookup hits.
- R6: A refill answer with `walk_resident` = 0 produces `resp_fault` = 1 and `resp_fault_vpn` = the missed page on the next clock, with `resp_valid` = 0. Nothing is installed, so a repeat lookup refills again.
- R7: The refill target is the lowest-indexed invalid entry. When every entry is valid, the target is a round-robin pointer that starts at entry 0 and advances by one after each replacement. Once `DEPTH` entries have been filled, a further miss therefore evicts the oldest fill, and the miss after that evicts the second oldest.
- R8: A clock with `flush_all` = 1 invalidates every entry.
- R9: A clock with `flush_ctx_en` = 1 invalidates only the entries whose context equals `flush_ctx`. Entries of other contexts still hit.
- R10: While `flush_all` or `flush_ctx_en` is 1, `req_ready` is 0 and a presented request is not accepted: no result and no refill follow from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this clock |
| req_ctx | input | CTX_W | Context of the lookup |
| req_vaddr | input | VPN_W+OFF_W | Virtual address: page number above offset |
| resp_valid | output | 1 | One-clock pulse: translated address available |
| resp_paddr | output | PPN_W+OFF_W | Physical address of the last result |
| resp_dirty | output | 1 | Dirty flag of the translated page |
| resp_fault | output | 1 | One-clock pulse: refilled page not resident |
| resp_fault_vpn | output | VPN_W | Virtual page number that faulted |
| walk_req | output | 1 | Refill request to the page map |
| walk_ctx | output | CTX_W | Context of the refill |
| walk_vpn | output | VPN_W | Page number to look up |
| walk_ack | input | 1 | Page-map answer valid |
| walk_resident | input | 1 | Page is resident |
| walk_ppn | input | PPN_W | Physical page number from the page map |
| walk_dirty | input | 1 | Dirty flag from the page map |
| flush_all | input | 1 | Invalidate all entries |
| flush_ctx_en | input | 1 | Invalidate the entries of one context |
| flush_ctx | input | CTX_W | Context to invalidate |

## Verification
The hardest state to reach from the ports is a full buffer, where the round-robin pointer and not the free-slot search picks the victim. The stimulus flushes everything and then fills all 64 slots with distinct pages of one context. It then misses on a new page, and on the oldest page after that. The refill counts show which entry went first and which went second. Context isolation is driven by mapping one page number under two contexts to different physical pages, and then flushing a third context around them.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } tlb_state_e;
endpackage

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match #(
    parameter int DEPTH = 64,
    parameter int CTX_W = 4,
    parameter int VPN_W = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            ent_valid,
    input  logic [DEPTH-1:0][CTX_W-1:0] ent_ctx,
    input  logic [DEPTH-1:0][VPN_W-1:0] ent_vpn,
    input  logic [CTX_W-1:0]            key_ctx,
    input  logic [VPN_W-1:0]            key_vpn,
    output logic [DEPTH-1:0]            hit_vec,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_idx
);
    // one comparator per entry, all in parallel
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = ent_valid[g] && (ent_ctx[g] == key_ctx)
                            && (ent_vpn[g] == key_vpn);
    end

    assign hit = |hit_vec;

    // OR-encode the (at most one-hot) hit vector
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) begin
                hit_idx = hit_idx | IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] ent_valid,
    input  logic             install,
    output logic [IDX_W-1:0] victim_idx
);
    logic [IDX_W-1:0] rr_d, rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // lowest-indexed free slot
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign any_free   = ~&ent_valid;
    assign victim_idx = any_free ? free_idx : rr_q;

    always_comb begin
        rr_d = rr_q;
        if (install && !any_free) begin
            rr_d = (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else begin
            rr_q <= rr_d;
        end
    end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CTX_W = 4,
    parameter int VPN_W = 20,
    parameter int PPN_W = 16,
    parameter int OFF_W = 12,
    localparam int VA_W  = VPN_W + OFF_W,
    localparam int PA_W  = PPN_W + OFF_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CTX_W-1:0] req_ctx,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_dirty,
    output logic             resp_fault,
    output logic [VPN_W-1:0] resp_fault_vpn,
    output logic             walk_req,
    output logic [CTX_W-1:0] walk_ctx,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             walk_ack,
    input  logic             walk_resident,
    input  logic [PPN_W-1:0] walk_ppn,
    input  logic             walk_dirty,
    input  logic             flush_all,
    input  logic             flush_ctx_en,
    input  logic [CTX_W-1:0] flush_ctx
);
    typedef struct packed {
        logic [CTX_W-1:0] ctx;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic             dirty;
    } entry_t;

    typedef struct packed {
        tlb_state_e            st;
        logic [DEPTH-1:0]      valid;
        entry_t [DEPTH-1:0]    ent;
        logic [CTX_W-1:0]      pend_ctx;
        logic [VA_W-1:0]       pend_va;
        logic                  walk_req;
        logic                  resp_valid;
        logic [PA_W-1:0]       resp_paddr;
        logic                  resp_dirty;
        logic                  resp_fault;
        logic [VPN_W-1:0]      fault_vpn;
    } regs_t;

    regs_t r_d, r_q;

    logic [DEPTH-1:0]            hit_vec;
    logic                        hit;
    logic [IDX_W-1:0]            hit_idx;
    logic [IDX_W-1:0]            victim_idx;
    logic [DEPTH-1:0][CTX_W-1:0] ent_ctx;
    logic [DEPTH-1:0][VPN_W-1:0] ent_vpn;
    logic                        flush_any;
    logic                        accept;
    logic                        install;

    for (genvar g = 0; g < DEPTH; g++) begin : g_view
        assign ent_ctx[g] = r_q.ent[g].ctx;
        assign ent_vpn[g] = r_q.ent[g].vpn;
    end

    ctx_tlb_match #(
        .DEPTH(DEPTH), .CTX_W(CTX_W), .VPN_W(VPN_W)
    ) u_match (
        .ent_valid(r_q.valid),
        .ent_ctx  (ent_ctx),
        .ent_vpn  (ent_vpn),
        .key_ctx  (req_ctx),
        .key_vpn  (req_vaddr[VA_W-1:OFF_W]),
        .hit_vec  (hit_vec),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    ctx_tlb_victim #(
        .DEPTH(DEPTH)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_valid (r_q.valid),
        .install   (install),
        .victim_idx(victim_idx)
    );

    assign flush_any = flush_all || flush_ctx_en;
    assign req_ready = (r_q.st == ST_IDLE) && !flush_any;
    assign accept    = req_valid && req_ready;
    assign install   = (r_q.st == ST_WALK) && walk_ack && walk_resident;

    always_comb begin
        r_d            = r_q;
        r_d.resp_valid = 1'b0;
        r_d.resp_fault = 1'b0;

        // invalidation first, so a same-cycle install survives it
        if (flush_all) begin
            r_d.valid = '0;
        end else if (flush_ctx_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (r_q.ent[i].ctx == flush_ctx) begin
                    r_d.valid[i] = 1'b0;
                end
            end
        end

        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (hit) begin
                        r_d.resp_valid = 1'b1;
                        r_d.resp_paddr = {r_q.ent[hit_idx].ppn,
                                          req_vaddr[OFF_W-1:0]};
                        r_d.resp_dirty = r_q.ent[hit_idx].dirty;
                    end else begin
                        r_d.st       = ST_WALK;
                        r_d.pend_ctx = req_ctx;
                        r_d.pend_va  = req_vaddr;
                        r_d.walk_req = 1'b1;
                    end
                end
            end
            ST_WALK: begin
                if (walk_ack) begin
                    r_d.st       = ST_IDLE;
                    r_d.walk_req = 1'b0;
                    if (walk_resident) begin
                        r_d.valid[victim_idx]     = 1'b1;
                        r_d.ent[victim_idx].ctx   = r_q.pend_ctx;
                        r_d.ent[victim_idx].vpn   = r_q.pend_va[VA_W-1:OFF_W];
                        r_d.ent[victim_idx].ppn   = walk_ppn;
                        r_d.ent[victim_idx].dirty = walk_dirty;
                        r_d.resp_valid = 1'b1;
                        r_d.resp_paddr = {walk_ppn, r_q.pend_va[OFF_W-1:0]};
                        r_d.resp_dirty = walk_dirty;
                    end else begin
                        r_d.resp_fault = 1'b1;
                        r_d.fault_vpn  = r_q.pend_va[VA_W-1:OFF_W];
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign resp_valid     = r_q.resp_valid;
    assign resp_paddr     = r_q.resp_paddr;
    assign resp_dirty     = r_q.resp_dirty;
    assign resp_fault     = r_q.resp_fault;
    assign resp_fault_vpn = r_q.fault_vpn;
    assign walk_req       = r_q.walk_req;
    assign walk_ctx       = r_q.pend_ctx;
    assign walk_vpn       = r_q.pend_va[VA_W-1:OFF_W];
endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
    parameter int DEPTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             walk_req,
    input logic             walk_ack,
    input logic             walk_resident,
    input logic             resp_valid,
    input logic             resp_fault,
    input logic [DEPTH-1:0] hit_vec
);
    // R3
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R4
    single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !req_ready);

    // R4
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !walk_ack |=> walk_req);

    // R2
    accept_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> resp_valid || walk_req);

    // R5
    refill_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && walk_ack && walk_resident |=> resp_valid && !walk_req);

    // R6
    fault_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && walk_ack && !walk_resident |=> resp_fault && !resp_valid);

    // R6
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && resp_fault));
endmodule

bind ctx_tlb ctx_tlb_chk #(.DEPTH(DEPTH)) u_ctx_tlb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .walk_req     (walk_req),
    .walk_ack     (walk_ack),
    .walk_resident(walk_resident),
    .resp_valid   (resp_valid),
    .resp_fault   (resp_fault),
    .hit_vec      (hit_vec)
);

// File: tb/ctx_tlb_bench.sv
module ctx_tlb_bench;
    localparam int CTX_W = 4;
    localparam int VPN_W = 20;
    localparam int PPN_W = 16;
    localparam int OFF_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [CTX_W-1:0] req_ctx = '0;
    logic [VPN_W+OFF_W-1:0] req_vaddr = '0;
    logic resp_valid, resp_dirty, resp_fault;
    logic [PPN_W+OFF_W-1:0] resp_paddr;
    logic [VPN_W-1:0] resp_fault_vpn;
    logic walk_req;
    logic [CTX_W-1:0] walk_ctx;
    logic [VPN_W-1:0] walk_vpn;
    logic walk_ack = 1'b0, walk_resident = 1'b0, walk_dirty = 1'b0;
    logic [PPN_W-1:0] walk_ppn = '0;
    logic flush_all = 1'b0, flush_ctx_en = 1'b0;
    logic [CTX_W-1:0] flush_ctx = '0;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ctx_tlb u_ctx_tlb (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_ctx(req_ctx), .req_vaddr(req_vaddr),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_dirty(resp_dirty), .resp_fault(resp_fault),
        .resp_fault_vpn(resp_fault_vpn),
        .walk_req(walk_req), .walk_ctx(walk_ctx), .walk_vpn(walk_vpn),
        .walk_ack(walk_ack), .walk_resident(walk_resident),
        .walk_ppn(walk_ppn), .walk_dirty(walk_dirty),
        .flush_all(flush_all), .flush_ctx_en(flush_ctx_en),
        .flush_ctx(flush_ctx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // results of the last lookup
    bit               lk_walked;
    bit               lk_fault;
    logic [27:0]      lk_pa;
    bit               lk_dirty;
    int               lk_lat;
    logic [VPN_W-1:0] lk_fvpn;

    function automatic logic [27:0] exp_pa(input logic [3:0] c, input logic [19:0] v,
                                           input logic [11:0] o);
        return {c, v[11:0], o};
    endfunction

    // page-map model: ppn = {ctx, vpn[11:0]}, dirty = vpn[0], non-resident when vpn[7:0] = FF
    task automatic lookup(input logic [3:0] c, input logic [19:0] v, input logic [11:0] o,
                          input string req);
        lk_walked = 0;
        lk_lat    = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_ctx   = c;
        req_vaddr = {v, o};
        @(negedge clk);
        req_valid = 1'b0;
        lk_lat    = 1;
        for (int k = 0; k < 20; k++) begin
            if (resp_valid || resp_fault) break;
            if (walk_req) begin
                lk_walked = 1;
                chk(walk_ctx == c, "R4", "walk ctx", 32'(walk_ctx), 32'(c));
                chk(walk_vpn == v, "R4", "walk vpn", 32'(walk_vpn), 32'(v));
                chk(!req_ready, "R4", "ready during walk", 32'(req_ready), 0);
                walk_ack      = 1'b1;
                walk_resident = (v[7:0] != 8'hFF);
                walk_ppn      = {c, v[11:0]};
                walk_dirty    = v[0];
                @(negedge clk);
                walk_ack = 1'b0;
            end else begin
                @(negedge clk);
            end
            lk_lat++;
        end
        if (!(resp_valid || resp_fault))
            chk(0, req, "no result", 0, 1);
        lk_fault = resp_fault;
        lk_pa    = resp_paddr;
        lk_dirty = resp_dirty;
        lk_fvpn  = resp_fault_vpn;
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
        chk(resp_valid == 1'b0, "R1", "resp_valid after reset", 32'(resp_valid), 0);
        chk(walk_req == 1'b0, "R1", "walk_req after reset", 32'(walk_req), 0);
        lookup(4'd1, 20'h00011, 12'h0AB, "R1");
        chk(lk_walked, "R1", "first lookup refills", 32'(lk_walked), 1);
    endtask

    task automatic t_miss_hit;
        lookup(4'd1, 20'h00020, 12'h123, "R5");
        chk(lk_walked, "R4", "miss refills", 32'(lk_walked), 1);
        chk(lk_pa == exp_pa(4'd1, 20'h00020, 12'h123), "R5", "refill paddr",
            32'(lk_pa), 32'(exp_pa(4'd1, 20'h00020, 12'h123)));
        lookup(4'd1, 20'h00020, 12'hFFE, "R2");
        chk(!lk_walked, "R2", "hit no refill", 32'(lk_walked), 0);
        chk(lk_lat == 1, "R2", "hit latency", 32'(lk_lat), 1);
        chk(lk_pa == exp_pa(4'd1, 20'h00020, 12'hFFE), "R2", "hit paddr",
            32'(lk_pa), 32'(exp_pa(4'd1, 20'h00020, 12'hFFE)));
        lookup(4'd1, 20'h00011, 12'h001, "R2");
        chk(lk_dirty == 1'b1, "R2", "hit dirty", 32'(lk_dirty), 1);
    endtask

    task automatic t_context;
        lookup(4'd2, 20'h00020, 12'h010, "R3");
        chk(lk_walked, "R3", "other ctx misses", 32'(lk_walked), 1);
        lookup(4'd2, 20'h00020, 12'h010, "R3");
        chk(!lk_walked && lk_pa == exp_pa(4'd2, 20'h00020, 12'h010), "R3", "ctx2 hit paddr",
            32'(lk_pa), 32'(exp_pa(4'd2, 20'h00020, 12'h010)));
        lookup(4'd1, 20'h00020, 12'h010, "R3");
        chk(!lk_walked && lk_pa == exp_pa(4'd1, 20'h00020, 12'h010), "R3", "ctx1 hit paddr",
            32'(lk_pa), 32'(exp_pa(4'd1, 20'h00020, 12'h010)));
    endtask

    task automatic t_fault;
        lookup(4'd1, 20'h004FF, 12'h000, "R6");
        chk(lk_fault, "R6", "fault raised", 32'(lk_fault), 1);
        chk(lk_fvpn == 20'h004FF, "R6", "fault vpn", 32'(lk_fvpn), 32'h004FF);
        lookup(4'd1, 20'h004FF, 12'h000, "R6");
        chk(lk_walked, "R6", "not installed", 32'(lk_walked), 1);
    endtask

    task automatic t_flush_ctx;
        lookup(4'd3, 20'h00033, 12'h000, "R9");
        @(negedge clk);
        flush_ctx_en = 1'b1;
        flush_ctx    = 4'd2;
        @(negedge clk);
        flush_ctx_en = 1'b0;
        lookup(4'd1, 20'h00020, 12'h000, "R9");
        chk(!lk_walked, "R9", "ctx1 kept", 32'(lk_walked), 0);
        lookup(4'd3, 20'h00033, 12'h000, "R9");
        chk(!lk_walked, "R9", "ctx3 kept", 32'(lk_walked), 0);
        lookup(4'd2, 20'h00020, 12'h000, "R9");
        chk(lk_walked, "R9", "ctx2 flushed", 32'(lk_walked), 1);
    endtask

    task automatic t_flush_all;
        @(negedge clk);
        flush_all = 1'b1;
        req_valid = 1'b1;
        req_ctx   = 4'd1;
        req_vaddr = {20'h00020, 12'h000};
        #1;
        chk(req_ready == 1'b0, "R10", "ready during flush", 32'(req_ready), 0);
        @(negedge clk);
        flush_all = 1'b0;
        req_valid = 1'b0;
        chk(!resp_valid && !walk_req, "R10", "request ignored",
            32'({resp_valid, walk_req}), 0);
        lookup(4'd1, 20'h00020, 12'h000, "R8");
        chk(lk_walked, "R8", "ctx1 flushed", 32'(lk_walked), 1);
        lookup(4'd3, 20'h00033, 12'h000, "R8");
        chk(lk_walked, "R8", "ctx3 flushed", 32'(lk_walked), 1);
    endtask

    task automatic t_victim;
        int refills;
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        refills = 0;
        for (int i = 0; i < 64; i++) begin
            lookup(4'd5, 20'h00100 + 20'(i), 12'h000, "R7");
            if (lk_walked) refills++;
        end
        chk(refills == 64, "R7", "fill refills", 32'(refills), 64);
        lookup(4'd5, 20'h0013F, 12'h000, "R7");
        chk(!lk_walked, "R7", "last fill hits", 32'(lk_walked), 0);
        lookup(4'd5, 20'h00200, 12'h000, "R7");
        chk(lk_walked, "R7", "extra page refills", 32'(lk_walked), 1);
        lookup(4'd5, 20'h00100, 12'h000, "R7");
        chk(lk_walked, "R7", "oldest evicted", 32'(lk_walked), 1);
        lookup(4'd5, 20'h00102, 12'h000, "R7");
        chk(!lk_walked, "R7", "third kept", 32'(lk_walked), 0);
        lookup(4'd5, 20'h00101, 12'h000, "R7");
        chk(lk_walked, "R7", "second evicted", 32'(lk_walked), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_hit();
        t_context();
        t_fault();
        t_flush_ctx();
        t_flush_all();
        t_victim();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule